// File: doc/BRIEF.md
# Received-Strength Sample-and-Hold Register

This block stores a 5-bit received-signal-strength value taken from a measurement bus that changes all the time. It turns that bus into a stable value that software can read. It takes a sample by itself when the packet receiver reports a start-of-packet. Each time software reads the register, the block arms a new sample to replace the value just returned. Software can therefore poll the energy on an idle channel by reading the register again and again.

Samples are rate-limited. After any capture, the next one can land only after a minimum interval, counted in system clock cycles. The default is 144 cycles, which is 12 µs at 12 MHz. A request that arrives inside the interval is remembered and served when the interval runs out; it is not dropped. The register means something only in receive mode. When receive mode is off, the block freezes its output and discards any request that has not yet been served.

Top module: `rssi_sample_hold`

## Requirements
- R1: While reset is high, and after it is released with no other stimulus, `rssi_q` is 0 and `rssi_valid` is 0.
- R2: A `sop_pulse` in receive mode, with the interval elapsed, loads the `meas_in` value present in that cycle into `rssi_q` at the same clock edge, and sets `rssi_valid` to 1.
- R3: A `rd_strobe` in receive mode, in a cycle with no capture, clears `rssi_valid` at that edge and leaves `rssi_q` unchanged. If the interval has elapsed, the replacement sample lands at the next edge, taken from `meas_in` in that following cycle.
- R4: Two captures are never closer than `MIN_GAP` clock cycles (default 144). The interval restarts at every capture.
- R5: A read made inside the interval is deferred, not dropped. The sample lands at the first edge on which the interval has expired, using `meas_in` from that cycle, and `rssi_valid` stays 0 until then.
- R6: A start-of-packet inside the interval is also deferred. It produces one capture when the interval expires.
- R7: A start-of-packet in the same cycle as a read, or while a read is pending, makes a single capture that also serves the read: `rssi_valid` becomes 1, and no second capture follows.
- R8: While `rx_en` is 0, `rssi_q` and `rssi_valid` hold their values, and reads and start-of-packet pulses have no effect. Pending requests are discarded, so returning to receive mode does not cause a capture by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | High while the receiver is in receive mode |
| meas_in | input | RSSI_W (5) | Free-running strength measurement |
| sop_pulse | input | 1 | One-cycle start-of-packet indication |
| rd_strobe | input | 1 | One-cycle pulse when software reads the register |
| rssi_q | output | RSSI_W (5) | Held strength value |
| rssi_valid | output | 1 | High when `rssi_q` holds a sample not yet read |

## Verification
The assertions assume that `sop_pulse` and `rd_strobe` are sampled only at clock edges, and that `meas_in` is stable around each edge. The stimulus drives all inputs on the falling edge, so every value is settled well before the rising edge that samples it. The checks on held values assume the only way out of a held state is a capture or a read. The stimulus therefore keeps reset low for the whole table. The bench uses a short interval, so that deferral, expiry and the idle edge after expiry all fall within a few cycles of each other.

// File: rtl/rssi_sh_pkg.sv
package rssi_sh_pkg;

    localparam int RSSI_W_DEF  = 5;
    localparam int MIN_GAP_DEF = 144;

    // Origin of the request that drives a capture.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SOP  = 2'd1,
        SRC_READ = 2'd2
    } cap_src_e;

    // Start-of-packet (live or latched) outranks a read request.
    function automatic cap_src_e pick_src(input logic sop_now,
                                          input logic sop_held,
                                          input logic rd_held);
        if (sop_now || sop_held) return SRC_SOP;
        if (rd_held)             return SRC_READ;
        return SRC_NONE;
    endfunction

    // Counter width that can hold the reload value gap-1.
    function automatic int gap_cnt_w(input int gap);
        return (gap < 2) ? 1 : $clog2(gap);
    endfunction

endpackage

// File: rtl/rssi_gap_timer.sv
module rssi_gap_timer
    import rssi_sh_pkg::*;
#(
    parameter int MIN_GAP = MIN_GAP_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic ready
);
    localparam int CW = gap_cnt_w(MIN_GAP);
    localparam logic [CW-1:0] RELOAD = CW'(MIN_GAP - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= RELOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign ready = (remain == '0);

endmodule

// File: rtl/rssi_req_arbiter.sv
module rssi_req_arbiter
    import rssi_sh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic sop_pulse,
    input  logic rd_strobe,
    input  logic gap_ready,
    output logic fire
);
    logic     sop_held, rd_held;
    cap_src_e src;

    always_comb begin
        src  = pick_src(sop_pulse, sop_held, rd_held);
        fire = rx_en && gap_ready && (src != SRC_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en || fire) begin
            sop_held <= 1'b0;
            rd_held  <= 1'b0;
        end else begin
            sop_held <= sop_held | sop_pulse;
            rd_held  <= rd_held  | rd_strobe;
        end
    end

endmodule

// File: rtl/rssi_hold_reg.sv
module rssi_hold_reg
    import rssi_sh_pkg::*;
#(
    parameter int RSSI_W = RSSI_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              fire,
    input  logic              rd_strobe,
    input  logic [RSSI_W-1:0] meas_in,
    output logic [RSSI_W-1:0] value,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            valid <= 1'b0;
        end else if (rx_en) begin
            if (fire) begin
                value <= meas_in;
                valid <= 1'b1;
            end else if (rd_strobe) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rssi_sample_hold.sv
module rssi_sample_hold
    import rssi_sh_pkg::*;
#(
    parameter int RSSI_W  = RSSI_W_DEF,
    parameter int MIN_GAP = MIN_GAP_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [RSSI_W-1:0] meas_in,
    input  logic              sop_pulse,
    input  logic              rd_strobe,
    output logic [RSSI_W-1:0] rssi_q,
    output logic              rssi_valid
);
    logic gap_ready;
    logic cap_fire;

    rssi_gap_timer #(.MIN_GAP(MIN_GAP)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .load  (cap_fire),
        .ready (gap_ready)
    );

    rssi_req_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .sop_pulse (sop_pulse),
        .rd_strobe (rd_strobe),
        .gap_ready (gap_ready),
        .fire      (cap_fire)
    );

    rssi_hold_reg #(.RSSI_W(RSSI_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .fire      (cap_fire),
        .rd_strobe (rd_strobe),
        .meas_in   (meas_in),
        .value     (rssi_q),
        .valid     (rssi_valid)
    );

endmodule

// File: rtl/rssi_sh_chk.sv
module rssi_sh_chk #(
    parameter int RSSI_W  = 5,
    parameter int MIN_GAP = 144
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_en,
    input logic [RSSI_W-1:0] meas_in,
    input logic              sop_pulse,
    input logic              rd_strobe,
    input logic [RSSI_W-1:0] rssi_q,
    input logic              rssi_valid,
    input logic              cap_fire
);
    localparam int SW = $clog2(MIN_GAP + 1);
    localparam logic [SW-1:0] SAT = SW'(MIN_GAP);

    logic [SW-1:0] since;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (cap_fire) begin
            since <= '0;
            seen  <= 1'b1;
        end else if (since != SAT) begin
            since <= since + 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (rssi_q == '0) && !rssi_valid); // R1

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
        cap_fire |=> rssi_valid && (rssi_q == $past(meas_in))); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rx_en && rd_strobe && !cap_fire) |=> !rssi_valid && $stable(rssi_q)); // R3

    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
        (cap_fire && seen) |-> (since >= SW'(MIN_GAP - 1))); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> $stable(rssi_q) && $stable(rssi_valid)); // R8

    AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        !rx_en |-> !cap_fire); // R8

endmodule

bind rssi_sample_hold rssi_sh_chk #(.RSSI_W(RSSI_W), .MIN_GAP(MIN_GAP)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .meas_in    (meas_in),
    .sop_pulse  (sop_pulse),
    .rd_strobe  (rd_strobe),
    .rssi_q     (rssi_q),
    .rssi_valid (rssi_valid),
    .cap_fire   (cap_fire)
);

// File: tb/sim_rssi_sample_hold.sv
module sim_rssi_sample_hold;

    localparam int W   = 5;
    localparam int GAP = 6;
    localparam int NROW = 30;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rx_en = 1'b0;
    logic [W-1:0] meas_in = '0;
    logic         sop_pulse = 1'b0;
    logic         rd_strobe = 1'b0;
    logic [W-1:0] rssi_q;
    logic         rssi_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rssi_sample_hold #(.RSSI_W(W), .MIN_GAP(GAP)) u0 (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .meas_in    (meas_in),
        .sop_pulse  (sop_pulse),
        .rd_strobe  (rd_strobe),
        .rssi_q     (rssi_q),
        .rssi_valid (rssi_valid)
    );

    // Row layout: rx, sop, rd, meas[5], exp_q[5], exp_v, req[6]
    function automatic logic [19:0] mk(input logic rx, input logic sop, input logic rd,
                                       input int meas, input int eq, input logic ev,
                                       input int req);
        return {rx, sop, rd, 5'(meas), 5'(eq), ev, 6'(req)};
    endfunction

    localparam logic [19:0] TBL [NROW] = '{
        mk(1,0,0, 3,  0,0, 1),  // R1 idle after reset
        mk(1,1,0, 9,  9,1, 2),  // R2 sop capture
        mk(1,0,1, 4,  9,0, 5),  // R5 read in interval
        mk(1,0,0, 4,  9,0, 5),
        mk(1,0,0, 5,  9,0, 5),
        mk(1,0,0, 6,  9,0, 5),
        mk(1,0,0, 7,  9,0, 4),  // R4 not yet
        mk(1,0,0,11, 11,1, 5),  // R5 deferred lands
        mk(1,1,0,20, 11,1, 6),  // R6 sop in interval
        mk(1,0,0,21, 11,1, 6),
        mk(1,0,0,21, 11,1, 6),
        mk(1,0,0,21, 11,1, 6),
        mk(1,0,0,21, 11,1, 4),  // R4
        mk(1,0,0,22, 22,1, 6),  // R6 deferred sop lands
        mk(0,0,1, 1, 22,1, 8),  // R8 read ignored
        mk(0,1,0, 2, 22,1, 8),  // R8 sop ignored
        mk(1,0,1, 3, 22,0, 3),  // R3 read clears valid
        mk(0,0,0, 4, 22,0, 8),  // R8 pending dropped
        mk(0,0,0, 4, 22,0, 8),
        mk(1,0,0, 5, 22,0, 8),
        mk(1,0,0, 5, 22,0, 8),
        mk(1,1,1,30, 30,1, 7),  // R7 sop with read
        mk(1,0,0,31, 30,1, 7),
        mk(1,0,0,31, 30,1, 7),
        mk(1,0,0,31, 30,1, 7),
        mk(1,0,0,31, 30,1, 7),
        mk(1,0,0,31, 30,1, 7),
        mk(1,0,0,31, 30,1, 7),  // R7 no second capture
        mk(1,0,1, 8, 30,0, 3),  // R3 read at ready
        mk(1,0,0,12, 12,1, 3)   // R3 sample lands next edge
    };

    task automatic check(input int req, input int tag, input logic [W-1:0] eq, input logic ev);
        n_chk++;
        if (rssi_q !== eq || rssi_valid !== ev) begin
            n_bad++;
            $display("FAIL R%0d step %0d: q=%0d v=%0b expected q=%0d v=%0b",
                     req, tag, rssi_q, rssi_valid, eq, ev);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, -1, '0, 1'b0);            // R1 during reset
        rst = 1'b0;
        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            rx_en     = TBL[i][19];
            sop_pulse = TBL[i][18];
            rd_strobe = TBL[i][17];
            meas_in   = TBL[i][16:12];
            @(posedge clk);
            #1;
            check(int'(TBL[i][5:0]), i, TBL[i][11:7], TBL[i][6]);
        end
        // R1: reset in the middle of operation clears the held state
        @(negedge clk);
        sop_pulse = 1'b0;
        rd_strobe = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(1, 100, '0, 1'b0);
        // R2: fresh sop right after reset release captures at once
        @(negedge clk);
        rst = 1'b0;
        sop_pulse = 1'b1;
        meas_in = 5'd17;
        @(posedge clk);
        #1;
        check(2, 101, 5'd17, 1'b1);
        // R4: back-to-back sop is held off for the interval
        @(negedge clk);
        meas_in = 5'd2;
        @(posedge clk);
        #1;
        check(4, 102, 5'd17, 1'b1);
        @(negedge clk);
        sop_pulse = 1'b0;
        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule